// File: doc/BRIEF.md
# Second-Operand Shifter with Carry

This block forms the second operand of a 32-bit ALU together with the carry that the shift produces. It accepts one of two operand forms. In the immediate form, an 8-bit constant is widened to 32 bits with zeros and rotated right by an even amount. In the register form, a register value is shifted left, shifted right logically or arithmetically, or rotated. The amount is either a 5-bit constant from the instruction or the low byte of a second register.

The shifter carry comes from the last bit moved out by the shift or rotate. Where nothing moves, the incoming carry flag is passed through. When the amount comes from a register, an extra-cycle indication is raised so that the sequencer can allow for the second register read. All three outputs are registered once. A result appears on the clock edge after its inputs are presented, and reset clears the outputs to zero.

Top module: `opnd_shifter`

## Requirements
- R1: With `use_imm` high, `operand` is `imm_byte` zero-extended to 32 bits and rotated right by 2 × `imm_rot`, which gives 0 to 30 bits.
- R2: With `use_imm` high, `carry_out` is bit 31 of the rotated result when `imm_rot` is nonzero, and equals `carry_in` when `imm_rot` is zero.
- R3: `sh_type` selects the shift: 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate right. With a constant amount and type 0, `sh_const` gives 0 to 31 bits and `carry_out` is the last bit shifted out. An amount of 0 leaves the value and the carry unchanged.
- R4: With a constant amount and type 1 or 2, a `sh_const` of 1 to 31 shifts by that amount and a code of 0 means 32. A logical shift by 32 gives zero with carry equal to bit 31. An arithmetic shift by 32 fills every bit with bit 31 and sets the carry to bit 31.
- R5: With a constant amount and type 3, a `sh_const` of 1 to 31 rotates right and takes the carry from the last bit moved out. A code of 0 instead rotates right by one through the carry: the result is {`carry_in`, `rm_val`[31:1]} and `carry_out` is `rm_val`[0].
- R6: With `sh_by_reg` high, the amount is `rs_val`[7:0] and bits 31:8 have no effect. An amount of zero passes `rm_val` through and keeps `carry_in`.
- R7: For a register amount of 32 or more, the left shift gives zero with carry equal to bit 0 at 32 and 0 beyond 32. The logical right shift gives zero with carry equal to bit 31 at 32 and 0 beyond 32. The arithmetic right shift gives all bits equal to bit 31, with carry equal to bit 31.
- R8: For a register rotate, the result is `rm_val` rotated right by the amount modulo 32. When the amount is a nonzero multiple of 32, the value is unchanged and the carry is bit 31. Otherwise the carry is the last bit moved out.
- R9: `extra_cycle` is high exactly when `sh_by_reg` is high and `use_imm` is low.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| use_imm | input | 1 | Select the immediate form |
| imm_byte | input | 8 | Immediate constant |
| imm_rot | input | 4 | Immediate rotation, in units of two bits |
| rm_val | input | 32 | Value to be shifted |
| sh_type | input | 2 | Shift type |
| sh_by_reg | input | 1 | Take the amount from `rs_val` |
| sh_const | input | 5 | Constant amount code |
| rs_val | input | 32 | Register holding the amount |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Shifted second operand |
| carry_out | output | 1 | Shifter carry |
| extra_cycle | output | 1 | Register-amount shift needs an extra cycle |

## Verification
The assertions assume that the inputs hold known values at every rising edge after reset. They also assume that each output is compared against the inputs of exactly one edge earlier, with no hold or stall. The stimulus meets this by changing inputs only on the falling edge and by presenting a new vector every cycle. The register-amount sweep covers amounts from 0 to 66 and a few large bytes, and it fills `rs_val`[31:8] with nonzero data so that the assumption that upper bits are ignored is actually exercised.

// File: rtl/opnd_shifter_pkg.sv
package opnd_shifter_pkg;
    parameter int unsigned OPND_W = 32;
    parameter int unsigned IMM_W  = 8;
    parameter int unsigned ROT_W  = 4;
    parameter int unsigned AMT_W  = 8;
    parameter int unsigned CST_W  = $clog2(OPND_W);

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } sh_kind_e;

    typedef struct packed {
        logic [OPND_W-1:0] operand;
        logic              carry;
        logic              extra;
    } opnd_out_s;
endpackage

// File: rtl/opnd_amt_decode.sv
module opnd_amt_decode
    import opnd_shifter_pkg::*;
(
    input  logic             by_reg,
    input  sh_kind_e         kind,
    input  logic [CST_W-1:0] const_amt,
    input  logic [AMT_W-1:0] reg_amt,
    output logic [AMT_W-1:0] amt,
    output logic             rrx
);
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(OPND_W);

    always_comb begin
        amt = AMT_W'(const_amt);
        rrx = 1'b0;
        if (by_reg) begin
            amt = reg_amt;
        end else if (const_amt == '0) begin
            case (kind)
                SH_LSR, SH_ASR: amt = FULL_AMT;
                SH_ROR: begin
                    amt = '0;
                    rrx = 1'b1;
                end
                default: amt = '0;
            endcase
        end
    end
endmodule

// File: rtl/opnd_imm_rotator.sv
module opnd_imm_rotator
    import opnd_shifter_pkg::*;
(
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    input  logic              cin,
    output logic [OPND_W-1:0] res,
    output logic              cout
);
    localparam int unsigned DBL_W = 2 * OPND_W;

    logic [OPND_W-1:0] wide;
    logic [DBL_W-1:0]  dbl;

    always_comb begin
        wide = OPND_W'(imm);
        dbl  = {wide, wide} >> {rot, 1'b0};
        res  = dbl[OPND_W-1:0];
        cout = (rot != '0) ? res[OPND_W-1] : cin;
    end
endmodule

// File: rtl/opnd_shift_core.sv
module opnd_shift_core
    import opnd_shifter_pkg::*;
(
    input  logic [OPND_W-1:0] val,
    input  logic [AMT_W-1:0]  amt,
    input  sh_kind_e          kind,
    input  logic              rrx,
    input  logic              cin,
    output logic [OPND_W-1:0] res,
    output logic              cout
);
    localparam int unsigned DBL_W = 2 * OPND_W;

    logic [OPND_W:0]        lsl_t;
    logic [OPND_W:0]        lsr_t;
    logic signed [OPND_W:0] asr_t;
    logic [DBL_W-1:0]       ror_t;
    logic [CST_W-1:0]       ror_n;

    always_comb begin
        lsl_t = {1'b0, val} << amt;
        lsr_t = {val, 1'b0} >> amt;
        asr_t = $signed({val, 1'b0}) >>> amt;
        ror_n = amt[CST_W-1:0];
        ror_t = {val, val} >> ror_n;
        res   = val;
        cout  = cin;
        if (rrx) begin
            res  = {cin, val[OPND_W-1:1]};
            cout = val[0];
        end else if (amt != '0) begin
            case (kind)
                SH_LSL: begin
                    res  = lsl_t[OPND_W-1:0];
                    cout = lsl_t[OPND_W];
                end
                SH_LSR: begin
                    res  = lsr_t[OPND_W:1];
                    cout = lsr_t[0];
                end
                SH_ASR: begin
                    res  = asr_t[OPND_W:1];
                    cout = asr_t[0];
                end
                default: begin
                    res  = ror_t[OPND_W-1:0];
                    cout = res[OPND_W-1];
                end
            endcase
        end
    end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
    import opnd_shifter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic [OPND_W-1:0] rm_val,
    input  logic [1:0]        sh_type,
    input  logic              sh_by_reg,
    input  logic [CST_W-1:0]  sh_const,
    input  logic [OPND_W-1:0] rs_val,
    input  logic              carry_in,
    output logic [OPND_W-1:0] operand,
    output logic              carry_out,
    output logic              extra_cycle
);
    sh_kind_e          kind;
    logic [AMT_W-1:0]  amt;
    logic              rrx;
    logic [OPND_W-1:0] imm_res;
    logic              imm_c;
    logic [OPND_W-1:0] sh_res;
    logic              sh_c;
    opnd_out_s         out_d;
    opnd_out_s         out_q;

    assign kind = sh_kind_e'(sh_type);

    opnd_amt_decode u_dec (
        .by_reg    (sh_by_reg),
        .kind      (kind),
        .const_amt (sh_const),
        .reg_amt   (rs_val[AMT_W-1:0]),
        .amt       (amt),
        .rrx       (rrx)
    );

    opnd_imm_rotator u_imm (
        .imm  (imm_byte),
        .rot  (imm_rot),
        .cin  (carry_in),
        .res  (imm_res),
        .cout (imm_c)
    );

    opnd_shift_core u_core (
        .val  (rm_val),
        .amt  (amt),
        .kind (kind),
        .rrx  (rrx),
        .cin  (carry_in),
        .res  (sh_res),
        .cout (sh_c)
    );

    always_comb begin
        out_d.operand = use_imm ? imm_res : sh_res;
        out_d.carry   = use_imm ? imm_c : sh_c;
        out_d.extra   = sh_by_reg & ~use_imm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign operand     = out_q.operand;
    assign carry_out   = out_q.carry;
    assign extra_cycle = out_q.extra;

    // R9: extra cycle flag follows a register amount one edge later
    p_extra_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_by_reg && !use_imm) |=> extra_cycle);
    p_no_extra_imm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        use_imm |=> !extra_cycle);

    // R2: immediate carry
    p_imm_carry_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm && imm_rot != '0) |=> (carry_out == operand[OPND_W-1]));
    p_imm_carry_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm && imm_rot == '0) |=> (carry_out == $past(carry_in)
                                        && operand == OPND_W'($past(imm_byte))));

    // R6: zero register amount passes through
    p_zero_reg_amt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && sh_by_reg && rs_val[AMT_W-1:0] == '0)
        |=> (operand == $past(rm_val) && carry_out == $past(carry_in)));

    // R5: one-bit rotate through carry
    p_rrx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && !sh_by_reg && sh_type == 2'd3 && sh_const == '0)
        |=> (operand == {$past(carry_in), $past(rm_val[OPND_W-1:1])}
             && carry_out == $past(rm_val[0])));

    // R4: logical right by 32 via constant code 0
    p_lsr32_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && !sh_by_reg && sh_type == 2'd1 && sh_const == '0)
        |=> (operand == '0 && carry_out == $past(rm_val[OPND_W-1])));
endmodule

// File: tb/sim_opnd_shifter.sv
`timescale 1ns/1ps
module sim_opnd_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        use_imm = 1'b0;
    logic [7:0]  imm_byte = '0;
    logic [3:0]  imm_rot = '0;
    logic [31:0] rm_val = '0;
    logic [1:0]  sh_type = '0;
    logic        sh_by_reg = 1'b0;
    logic [4:0]  sh_const = '0;
    logic [31:0] rs_val = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        carry_out;
    logic        extra_cycle;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    opnd_shifter u0 (
        .clk(clk), .rst_n(rst_n), .use_imm(use_imm), .imm_byte(imm_byte),
        .imm_rot(imm_rot), .rm_val(rm_val), .sh_type(sh_type),
        .sh_by_reg(sh_by_reg), .sh_const(sh_const), .rs_val(rs_val),
        .carry_in(carry_in), .operand(operand), .carry_out(carry_out),
        .extra_cycle(extra_cycle)
    );

    function automatic logic [31:0] pick_val(int i);
        case (i % 6)
            0: return 32'h8000_0001;
            1: return 32'h7FFF_FFFE;
            2: return 32'hDEAD_BEEF;
            3: return 32'h0000_0000;
            4: return 32'hFFFF_FFFF;
            default: return 32'h1234_5678;
        endcase
    endfunction

    // Bit-at-a-time reference model: returns {carry, operand}
    function automatic logic [32:0] model(logic imm, logic [7:0] ib, logic [3:0] ir,
                                          logic [31:0] v, logic [1:0] ty, logic byreg,
                                          logic [4:0] k, logic [31:0] rs, logic cin);
        logic [31:0] r;
        logic c;
        int n;
        c = cin;
        if (imm) begin
            r = {24'd0, ib};
            for (int i = 0; i < 2 * int'(ir); i++) r = {r[0], r[31:1]};
            if (ir != 0) c = r[31];
            return {c, r};
        end
        r = v;
        if (!byreg && ty == 2'd3 && k == 0) return {v[0], cin, v[31:1]};
        if (byreg) n = int'(rs[7:0]);
        else if (k == 0 && (ty == 2'd1 || ty == 2'd2)) n = 32;
        else n = int'(k);
        for (int i = 0; i < n; i++) begin
            case (ty)
                2'd0: begin c = r[31]; r = r << 1; end
                2'd1: begin c = r[0];  r = r >> 1; end
                2'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
                default: begin c = r[0]; r = {r[0], r[31:1]}; end
            endcase
        end
        return {c, r};
    endfunction

    task automatic check_out(string tag, logic [32:0] exp, logic exp_x);
        checks++;
        if ({carry_out, operand} !== exp || extra_cycle !== exp_x) begin
            fails++;
            $display("FAIL %s: got op=%h c=%b x=%b, expected op=%h c=%b x=%b",
                     tag, operand, carry_out, extra_cycle, exp[31:0], exp[32], exp_x);
        end
    endtask

    // Drive at falling edge, result registered at next rising edge, sample at falling edge
    task automatic apply(string tag, logic imm, logic [7:0] ib, logic [3:0] ir,
                         logic [31:0] v, logic [1:0] ty, logic byreg, logic [4:0] k,
                         logic [31:0] rs, logic cin);
        use_imm = imm; imm_byte = ib; imm_rot = ir; rm_val = v; sh_type = ty;
        sh_by_reg = byreg; sh_const = k; rs_val = rs; carry_in = cin;
        @(posedge clk);
        @(negedge clk);
        check_out(tag, model(imm, ib, ir, v, ty, byreg, k, rs, cin), byreg & ~imm);
    endtask

    function automatic string const_tag(logic [1:0] ty, logic [4:0] k);
        if (ty == 2'd0) return "R3";
        if (ty == 2'd3) return "R5";
        return (k == 0) ? "R4" : "R3";
    endfunction

    function automatic string reg_tag(logic [1:0] ty, int a);
        if (a == 0 || a > 255) return "R6";
        if (ty == 2'd3) return "R8";
        if (a >= 32) return "R7";
        return "R9";
    endfunction

    initial begin
        // R10: reset holds outputs at zero despite active inputs
        use_imm = 1'b0; rm_val = 32'hFFFF_FFFF; sh_by_reg = 1'b1; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        check_out("R10", 33'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2: every immediate and rotation
        for (int b = 0; b < 256; b++)
            for (int r = 0; r < 16; r++)
                apply((r == 0) ? "R2" : "R1", 1'b1, 8'(b), 4'(r), pick_val(b),
                      2'(b), b[0], 5'(r), 32'hFFFF_FF07, 1'(r));

        // R3, R4, R5: every constant code per type
        for (int t = 0; t < 4; t++)
            for (int k = 0; k < 32; k++)
                for (int i = 0; i < 6; i++)
                    for (int c = 0; c < 2; c++)
                        apply(const_tag(2'(t), 5'(k)), 1'b0, 8'hA5, 4'(k), pick_val(i),
                              2'(t), 1'b0, 5'(k), 32'h0000_0004, 1'(c));

        // R6, R7, R8, R9: register amounts with junk in upper bits
        for (int t = 0; t < 4; t++)
            for (int a = 0; a < 72; a++)
                for (int i = 0; i < 6; i++)
                    for (int c = 0; c < 2; c++) begin
                        int amt;
                        amt = (a < 67) ? a : ((a == 67) ? 127 : (a == 68) ? 128
                              : (a == 69) ? 200 : (a == 70) ? 255 : 256);
                        apply(reg_tag(2'(t), amt), 1'b0, 8'h3C, 4'(a), pick_val(i + a),
                              2'(t), 1'b1, 5'(a), {24'hC3A591, 8'(amt)} + ((amt > 255) ? 32'h100 : 32'h0),
                              1'(c));
                    end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R10: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule